// File: doc/BRIEF.md
# Shared-Address Register Sequencer

This block is the processor-facing register file of a serial line controller. The processor reaches it through a chip enable, a read/write select and a two-bit register select. Two of the four select codes each lead to a small group of registers behind one address: a three-entry group holding the two sync characters and the link-escape character, and a two-entry group holding the two mode words. An internal pointer for each group picks the register that the current access reaches. The pointer then moves on to the next register and wraps back to the first after the last one.

Reading the command register returns both pointers to the first entry of their groups. No other access moves a pointer backwards. The command word drives two active-low modem control outputs. One of its bits is an action bit that is never stored and produces an error-clear pulse. Setting the receiver-enable bit from 0 to 1 produces an arming pulse for the receiver. Accesses to the data address produce only read or write strobes, for the serial datapath outside this block.

Top module: `seq_regfile`

## Requirements
- R1: Select code 00 is the data address. A read there gives a one-cycle `data_rd_stb` and a write gives a one-cycle `data_wr_stb`, both in the cycle after the access edge. Neither changes any register or pointer.
- R2: Writes to select code 01 fill the sync group in the order first sync character, second sync character, escape character.
- R3: The access after the last register of a group reaches the first register of that group again.
- R4: Select code 10 reaches mode word 1 first and mode word 2 on the next access. Reads and writes share this one pointer.
- R5: Every access to select code 01 or 10 moves that group's pointer on by one. Accesses to the other group do not move it.
- R6: A read of select code 11 (command) returns both pointers to their first entries. Command writes and data accesses leave the pointers unchanged.
- R7: Bit 4 of a command write is never stored; it reads back as 0. When it is 1, `err_clr` goes high for exactly one cycle.
- R8: `dtr_n` is the inverse of command bit 1 and `rts_n` is the inverse of command bit 5.
- R9: A command write that takes bit 2 (receiver enable) from 0 to 1 gives a one-cycle `rx_arm` pulse. Writing 1 to that bit when it is already 1 gives no pulse.
- R10: After reset, every register reads zero, both pointers are at their first entry, `dtr_n` and `rts_n` are 1, and all pulses and strobes are low.
- R11: While `ce` is low, no register, pointer or strobe changes.
- R12: Read data appears on `rdata` in the cycle after the read edge and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce | input | 1 | Chip enable; each enabled cycle is one access |
| wr | input | 1 | 1 = write, 0 = read |
| sel | input | 2 | Register select code |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| syn1 | output | DATA_W | First sync character |
| syn2 | output | DATA_W | Second sync character |
| dle | output | DATA_W | Link-escape character |
| mode1 | output | DATA_W | Mode word 1 |
| mode2 | output | DATA_W | Mode word 2 |
| cmd | output | DATA_W | Stored command word |
| dtr_n | output | 1 | Inverse of command bit 1 |
| rts_n | output | 1 | Inverse of command bit 5 |
| err_clr | output | 1 | One-cycle error-clear pulse |
| rx_arm | output | 1 | One-cycle receiver arming pulse |
| data_rd_stb | output | 1 | Data register read strobe |
| data_wr_stb | output | 1 | Data register write strobe |

## Verification
The bench builds the block with its defaults: an 8-bit data width, three sync-group entries and two mode-group entries. With these sizes both pointers wrap within a handful of accesses. The bench can therefore run a full wrap of each group, interleave reads and writes on the shared mode pointer, and check that a command read clears pointers left at non-zero positions. The bench also checks that data and command writes leave those positions alone.

// File: rtl/seqreg_pkg.sv
package seqreg_pkg;
    typedef enum logic [1:0] {
        SEL_DATA = 2'b00,
        SEL_SYNC = 2'b01,
        SEL_MODE = 2'b10,
        SEL_CMD  = 2'b11
    } sel_e;

    localparam int BIT_DTR    = 1;
    localparam int BIT_RXEN   = 2;
    localparam int BIT_ERRCLR = 4;
    localparam int BIT_RTS    = 5;
endpackage

// File: rtl/seq_ptr.sv
module seq_ptr #(
    parameter int N = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 step,
    input  logic                 clr,
    output logic [$clog2(N)-1:0] idx
);
    localparam int W = $clog2(N);

    typedef struct packed {
        logic [W-1:0] idx;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr) begin
            s_d.idx = '0;
        end else if (step) begin
            s_d.idx = (s_q.idx == W'(N-1)) ? '0 : s_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign idx = s_q.idx;

    // R3: the step after the last entry returns to the first entry
    p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr && idx == W'(N-1)) |=> (idx == '0));

    // R6: without a step or a clear the pointer keeps its position
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !clr) |=> $stable(idx));

    // R5: a step away from the last entry moves the pointer on by one
    p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr && idx != W'(N-1)) |=> (idx == $past(idx) + 1'b1));
endmodule

// File: rtl/cmd_pulse.sv
module cmd_pulse #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rxen_now,
    output logic              err_clr,
    output logic              rx_arm
);
    import seqreg_pkg::*;

    typedef struct packed {
        logic err_clr;
        logic rx_arm;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d.err_clr = cmd_wr && wdata[BIT_ERRCLR];
        s_d.rx_arm  = cmd_wr && wdata[BIT_RXEN] && !rxen_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign err_clr = s_q.err_clr;
    assign rx_arm  = s_q.rx_arm;

    // R7: an error-clear pulse only ever follows a command write
    p_errclr_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_clr |-> $past(cmd_wr));
endmodule

// File: rtl/seq_regfile.sv
module seq_regfile #(
    parameter int DATA_W = 8,
    parameter int SYNC_N = 3,
    parameter int MODE_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce,
    input  logic              wr,
    input  logic [1:0]        sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] syn1,
    output logic [DATA_W-1:0] syn2,
    output logic [DATA_W-1:0] dle,
    output logic [DATA_W-1:0] mode1,
    output logic [DATA_W-1:0] mode2,
    output logic [DATA_W-1:0] cmd,
    output logic              dtr_n,
    output logic              rts_n,
    output logic              err_clr,
    output logic              rx_arm,
    output logic              data_rd_stb,
    output logic              data_wr_stb
);
    import seqreg_pkg::*;

    localparam int SW = $clog2(SYNC_N);
    localparam int MW = $clog2(MODE_N);
    localparam logic [DATA_W-1:0] KEEP_MASK = ~(DATA_W'(1) << BIT_ERRCLR);

    typedef struct packed {
        logic [SYNC_N-1:0][DATA_W-1:0] sync;
        logic [MODE_N-1:0][DATA_W-1:0] mode;
        logic [DATA_W-1:0]             cmd;
        logic [DATA_W-1:0]             rdata;
        logic                          drd;
        logic                          dwr;
    } st_t;

    st_t s_d, s_q;

    logic [SW-1:0] sidx;
    logic [MW-1:0] midx;
    logic          sync_step, mode_step, ptr_clr, cmd_wr;

    assign sync_step = ce && (sel == SEL_SYNC);
    assign mode_step = ce && (sel == SEL_MODE);
    assign ptr_clr   = ce && !wr && (sel == SEL_CMD);
    assign cmd_wr    = ce && wr && (sel == SEL_CMD);

    seq_ptr #(.N(SYNC_N)) u_sync_ptr (
        .clk(clk), .rst_n(rst_n), .step(sync_step), .clr(ptr_clr), .idx(sidx)
    );

    seq_ptr #(.N(MODE_N)) u_mode_ptr (
        .clk(clk), .rst_n(rst_n), .step(mode_step), .clr(ptr_clr), .idx(midx)
    );

    cmd_pulse #(.DATA_W(DATA_W)) u_pulse (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .wdata(wdata),
        .rxen_now(s_q.cmd[BIT_RXEN]), .err_clr(err_clr), .rx_arm(rx_arm)
    );

    always_comb begin
        s_d     = s_q;
        s_d.drd = 1'b0;
        s_d.dwr = 1'b0;
        if (ce) begin
            case (sel)
                SEL_DATA: begin
                    if (wr) s_d.dwr = 1'b1;
                    else    s_d.drd = 1'b1;
                end
                SEL_SYNC: begin
                    if (wr) s_d.sync[sidx] = wdata;
                    else    s_d.rdata      = s_q.sync[sidx];
                end
                SEL_MODE: begin
                    if (wr) s_d.mode[midx] = wdata;
                    else    s_d.rdata      = s_q.mode[midx];
                end
                default: begin
                    if (wr) s_d.cmd   = wdata & KEEP_MASK;
                    else    s_d.rdata = s_q.cmd;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rdata       = s_q.rdata;
    assign syn1        = s_q.sync[0];
    assign syn2        = s_q.sync[1];
    assign dle         = s_q.sync[2];
    assign mode1       = s_q.mode[0];
    assign mode2       = s_q.mode[1];
    assign cmd         = s_q.cmd;
    assign dtr_n       = ~s_q.cmd[BIT_DTR];
    assign rts_n       = ~s_q.cmd[BIT_RTS];
    assign data_rd_stb = s_q.drd;
    assign data_wr_stb = s_q.dwr;

    // R6: a command read leaves both pointers at their first entry
    p_ptr_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_clr |=> (sidx == '0 && midx == '0));

    // R11: with chip enable low the stored registers do not move
    p_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !ce |=> ($stable(s_q.cmd) && $stable(s_q.sync) && $stable(s_q.mode)
                 && !data_rd_stb && !data_wr_stb));

    // R9: an arming pulse coincides with the enable bit having just risen
    p_rx_arm_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_arm |-> (s_q.cmd[BIT_RXEN] && !$past(s_q.cmd[BIT_RXEN])));

    // R1: data strobes never overlap
    p_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(data_rd_stb && data_wr_stb));
endmodule

// File: tb/sim_seq_regfile.sv
`timescale 1ns/1ps
module sim_seq_regfile;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ce = 1'b0;
    logic       wr = 1'b0;
    logic [1:0] sel = 2'b00;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata, syn1, syn2, dle, mode1, mode2, cmd;
    logic       dtr_n, rts_n, err_clr, rx_arm, data_rd_stb, data_wr_stb;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    logic [7:0] q_exp[$];
    string      q_tag[$];

    always #5 clk = ~clk;

    seq_regfile u0 (
        .clk(clk), .rst_n(rst_n), .ce(ce), .wr(wr), .sel(sel), .wdata(wdata),
        .rdata(rdata), .syn1(syn1), .syn2(syn2), .dle(dle), .mode1(mode1),
        .mode2(mode2), .cmd(cmd), .dtr_n(dtr_n), .rts_n(rts_n),
        .err_clr(err_clr), .rx_arm(rx_arm), .data_rd_stb(data_rd_stb),
        .data_wr_stb(data_wr_stb)
    );

    task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string tag);
        compared++;
        if (got !== exp) begin
            mismatched++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic access(input logic w, input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        ce = 1'b1; wr = w; sel = s; wdata = d;
        @(posedge clk);
    endtask

    task automatic rd(input logic [1:0] s, input logic [7:0] exp, input string tag);
        access(1'b0, s, 8'h00);
        q_exp.push_back(exp);
        q_tag.push_back(tag);
    endtask

    task automatic idle();
        @(negedge clk);
        ce = 1'b0; wr = 1'b0;
    endtask

    // monitor: compares read data one half cycle after the read edge
    always @(negedge clk) begin
        if (q_exp.size() > 0) begin
            logic [7:0] e;
            string t;
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            chk(rdata, e, t);
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(cmd, 8'h00, "R10 cmd");
        chk(syn1 | syn2 | dle | mode1 | mode2, 8'h00, "R10 regs");
        chk({6'b0, dtr_n, rts_n}, 8'h03, "R10 modem outputs");
        chk({4'b0, err_clr, rx_arm, data_rd_stb, data_wr_stb}, 8'h00, "R10 pulses");

        // R11 ignored while ce low
        @(negedge clk); ce = 1'b0; wr = 1'b1; sel = 2'b11; wdata = 8'hFF;
        @(negedge clk);
        chk(cmd, 8'h00, "R11 cmd unchanged");
        chk({6'b0, err_clr, rx_arm}, 8'h00, "R11 no pulse");

        // R2 sync fill order
        access(1'b1, 2'b01, 8'hA1);
        access(1'b1, 2'b01, 8'hB2);
        access(1'b1, 2'b01, 8'hC3);
        idle();
        chk(syn1, 8'hA1, "R2 syn1");
        chk(syn2, 8'hB2, "R2 syn2");
        chk(dle,  8'hC3, "R2 dle");
        // R3 wrap of sync group
        access(1'b1, 2'b01, 8'h44);
        idle();
        chk(syn1, 8'h44, "R3 sync wrap to first");
        chk(syn2, 8'hB2, "R3 syn2 kept");

        // R4 mode sequence
        access(1'b1, 2'b10, 8'h11);
        access(1'b1, 2'b10, 8'h22);
        idle();
        chk(mode1, 8'h11, "R4 mode1");
        chk(mode2, 8'h22, "R4 mode2");
        rd(2'b10, 8'h11, "R4 read mode1 after wrap");
        rd(2'b10, 8'h22, "R4 read mode2");
        access(1'b1, 2'b10, 8'h33);
        idle();
        chk(mode1, 8'h33, "R5 mode wrap shared by read and write");
        chk(mode2, 8'h22, "R5 mode2 kept");

        // R12 sync read returns pointed register and holds
        rd(2'b01, 8'hB2, "R12 sync read at entry 2");
        idle();
        idle();
        chk(rdata, 8'hB2, "R12 rdata held");

        // R1 data strobes, pointers untouched
        access(1'b0, 2'b00, 8'h00);
        idle();
        chk({7'b0, data_rd_stb}, 8'h01, "R1 read strobe");
        chk({7'b0, data_wr_stb}, 8'h00, "R1 no write strobe");
        idle();
        chk({7'b0, data_rd_stb}, 8'h00, "R1 read strobe one cycle");
        access(1'b1, 2'b00, 8'h5A);
        idle();
        chk({7'b0, data_wr_stb}, 8'h01, "R1 write strobe");
        chk(syn1, 8'h44, "R1 no register change");
        access(1'b1, 2'b11, 8'h00);
        access(1'b1, 2'b01, 8'h77);
        idle();
        chk(dle, 8'h77, "R6 sync pointer kept through data and command writes");
        access(1'b1, 2'b01, 8'h88);
        idle();
        chk(syn1, 8'h88, "R5 sync pointer wraps");

        // R6 command read clears both pointers (sync at 1, mode at 1)
        rd(2'b11, 8'h00, "R6 command read value");
        access(1'b1, 2'b01, 8'h55);
        access(1'b1, 2'b10, 8'h66);
        idle();
        chk(syn1, 8'h55, "R6 sync pointer cleared");
        chk(syn2, 8'hB2, "R6 syn2 untouched");
        chk(mode1, 8'h66, "R6 mode pointer cleared");
        chk(mode2, 8'h22, "R6 mode2 untouched");

        // R7 error-clear bit
        access(1'b1, 2'b11, 8'h10);
        idle();
        chk(cmd, 8'h00, "R7 bit4 not stored");
        chk({7'b0, err_clr}, 8'h01, "R7 pulse");
        idle();
        chk({7'b0, err_clr}, 8'h00, "R7 pulse one cycle");

        // R8 modem outputs
        access(1'b1, 2'b11, 8'h22);
        idle();
        chk({6'b0, dtr_n, rts_n}, 8'h00, "R8 both asserted");
        access(1'b1, 2'b11, 8'h02);
        idle();
        chk({6'b0, dtr_n, rts_n}, 8'h01, "R8 rts released");

        // R9 receiver arming
        access(1'b1, 2'b11, 8'h04);
        idle();
        chk({7'b0, rx_arm}, 8'h01, "R9 arm on rise");
        idle();
        chk({7'b0, rx_arm}, 8'h00, "R9 arm one cycle");
        access(1'b1, 2'b11, 8'h04);
        idle();
        chk({7'b0, rx_arm}, 8'h00, "R9 no arm when already set");
        access(1'b1, 2'b11, 8'h00);
        access(1'b1, 2'b11, 8'h04);
        idle();
        chk({7'b0, rx_arm}, 8'h01, "R9 arm after clear");

        idle();
        idle();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule